// File: doc/BRIEF.md
# Exception Entry and Vectoring Controller

This block sits beside the pipeline of a small processor core and turns pending exception requests into a mode switch and a fetch redirect. Seven request lines can be raised: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. When the core pulses the entry-enable strobe, the controller gates the two interrupt lines with their mask bits in the current status word. It then picks the most urgent request that is left and builds the entry frame in a single cycle.

The entry frame has four parts. The first is a new status word carrying the target mode and updated mask bits. The second is a copy of the old status word for that mode's saved-status register. The third is a return address for that mode's banked link register. The fourth is the vector address that the fetch unit jumps to. The target mode is presented on `mode_out`, so the register file can pick the bank that receives the writes. All outputs are registered. They appear for exactly one cycle after the clock edge that sampled the strobe, and they return to zero otherwise.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), every output is zero: all strobes, `mode_out`, `vector_addr`, `sr_new`, `spsr_data` and `lr_data`.
- R2: When several unmasked requests are present at a sampled entry, the one taken is the first in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: The target mode on `mode_out` (5 bits) is 0x11 for fast interrupt, 0x12 for normal interrupt, 0x13 for reset and software interrupt, 0x17 for both aborts, and 0x1B for undefined instruction.
- R4: `vector_addr` equals `VEC_BASE` plus an offset. The offset is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R5: The normal interrupt request is ignored while bit 7 of `sr_in` is 1, and the fast interrupt request is ignored while bit 6 is 1. If no unmasked request remains, no strobe is raised. A lower-priority unmasked request is still taken.
- R6: `sr_new` equals `sr_in` with three changes: bits [4:0] are replaced by the target mode, and bit 7 is set. Bit 6 is also set for fast interrupt and reset entries; for every other entry, bit 6 keeps its value from `sr_in`.
- R7: For every entry except reset, `spsr_we` is 1 and `spsr_data` equals the `sr_in` that was sampled. A reset entry leaves `spsr_we` at 0.
- R8: For every entry except reset, `lr_we` is 1 and `lr_data` equals the sampled `pc_in` plus 4, modulo 2^DW. A reset entry leaves `lr_we` at 0.
- R9: An entry whose `entry_en` is sampled high at a rising edge raises `redirect` and `sr_we` together for the cycle that follows that edge. The frame values are valid in that same cycle.
- R10: When `entry_en` is sampled low, every strobe is 0 in the following cycle, whatever requests are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| entry_en | input | 1 | Entry-enable strobe from the core |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data access failure request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Instruction fetch failure request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| pc_in | input | DW | Address of the interrupted instruction |
| sr_in | input | DW | Current status word |
| redirect | output | 1 | Fetch redirect strobe |
| vector_addr | output | DW | Fetch redirect target |
| mode_out | output | 5 | Target mode, also the bank select for the writes |
| sr_we | output | 1 | Status word write strobe |
| sr_new | output | DW | New status word |
| spsr_we | output | 1 | Saved-status write strobe for bank `mode_out` |
| spsr_data | output | DW | Value for the saved-status register |
| lr_we | output | 1 | Link register write strobe for bank `mode_out` |
| lr_data | output | DW | Return address for the link register |

## Verification
The bench sweeps all 128 request combinations against all four settings of the two mask bits, and covers cases where masked interrupts sit beside, above and below other requests. This catches a wrong order in the priority chain: such a design would take the wrong vector when a data abort arrives together with a fast interrupt. It also catches a mask bit applied to the wrong interrupt, which would either lose a request or take one that should be ignored. A reset entry that wrongly writes the saved-status or link register would corrupt banked state, and a wrong rule for bit 6 would leave the fast interrupt unmasked inside its own handler; the bench checks for both. A return address that crosses the top of the address range, and requests held with the strobe low, are checked separately.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_EXC = 7;
  localparam int KIND_W  = $clog2(NUM_EXC);
  localparam int MODE_W  = 5;
  localparam int OFS_W   = 5;
  localparam int I_POS   = 7;
  localparam int F_POS   = 6;

  // Enumeration value equals priority rank, 0 is most urgent
  typedef enum logic [KIND_W-1:0] {
    K_RESET = 3'd0,
    K_DABT  = 3'd1,
    K_FIQ   = 3'd2,
    K_IRQ   = 3'd3,
    K_PABT  = 3'd4,
    K_UNDEF = 3'd5,
    K_SWI   = 3'd6
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  function automatic logic [MODE_W-1:0] kind_mode(exc_kind_e k);
    case (k)
      K_FIQ:          return MODE_FIQ;
      K_IRQ:          return MODE_IRQ;
      K_DABT, K_PABT: return MODE_ABT;
      K_UNDEF:        return MODE_UND;
      default:        return MODE_SVC;
    endcase
  endfunction

  function automatic logic [OFS_W-1:0] kind_offset(exc_kind_e k);
    case (k)
      K_RESET: return 5'h00;
      K_UNDEF: return 5'h04;
      K_SWI:   return 5'h08;
      K_PABT:  return 5'h0C;
      K_DABT:  return 5'h10;
      K_IRQ:   return 5'h18;
      default: return 5'h1C;
    endcase
  endfunction

  function automatic logic kind_sets_f(exc_kind_e k);
    return (k == K_RESET) || (k == K_FIQ);
  endfunction

  function automatic logic kind_saves(exc_kind_e k);
    return k != K_RESET;
  endfunction

endpackage

// File: rtl/exc_req_gate.sv
module exc_req_gate
  import exc_entry_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               req_reset,
  input  logic               req_dabt,
  input  logic               req_fiq,
  input  logic               req_irq,
  input  logic               req_pabt,
  input  logic               req_undef,
  input  logic               req_swi,
  input  logic [DW-1:0]      sr_in,
  output logic [NUM_EXC-1:0] ranked
);

  logic irq_block;
  logic fiq_block;

  assign irq_block = sr_in[I_POS];
  assign fiq_block = sr_in[F_POS];

  always_comb begin
    ranked          = '0;
    ranked[K_RESET] = req_reset;
    ranked[K_DABT]  = req_dabt;
    ranked[K_FIQ]   = req_fiq & ~fiq_block;
    ranked[K_IRQ]   = req_irq & ~irq_block;
    ranked[K_PABT]  = req_pabt;
    ranked[K_UNDEF] = req_undef;
    ranked[K_SWI]   = req_swi;
  end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 7,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N-1:0] above;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_top
        assign above[g] = 1'b0;
      end else begin : g_rest
        assign above[g] = above[g-1] | req[g-1];
      end
      assign grant[g] = req[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_entry_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  exc_kind_e         kind,
  input  logic [DW-1:0]     pc_in,
  input  logic [DW-1:0]     sr_in,
  output logic [MODE_W-1:0] mode,
  output logic [DW-1:0]     vec,
  output logic [DW-1:0]     sr_next,
  output logic [DW-1:0]     link,
  output logic              saves
);

  localparam logic [DW-1:0] LINK_STEP = DW'(4);

  function automatic logic [DW-1:0] build_sr(logic [DW-1:0] cur, exc_kind_e k);
    logic [DW-1:0] s;
    s              = cur;
    s[MODE_W-1:0]  = kind_mode(k);
    s[I_POS]       = 1'b1;
    if (kind_sets_f(k)) s[F_POS] = 1'b1;
    return s;
  endfunction

  assign mode    = kind_mode(kind);
  assign vec     = VEC_BASE + {{(DW-OFS_W){1'b0}}, kind_offset(kind)};
  assign sr_next = build_sr(sr_in, kind);
  assign link    = pc_in + LINK_STEP;
  assign saves   = kind_saves(kind);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_en,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic [DW-1:0]     pc_in,
  input  logic [DW-1:0]     sr_in,
  output logic              redirect,
  output logic [DW-1:0]     vector_addr,
  output logic [MODE_W-1:0] mode_out,
  output logic              sr_we,
  output logic [DW-1:0]     sr_new,
  output logic              spsr_we,
  output logic [DW-1:0]     spsr_data,
  output logic              lr_we,
  output logic [DW-1:0]     lr_data
);

  // Named internal events, observed by the bound checker
  logic [NUM_EXC-1:0] ranked_req;
  logic [NUM_EXC-1:0] grant_vec;
  logic [KIND_W-1:0]  win_idx;
  logic               win_any;
  logic               take;
  exc_kind_e          win_kind;

  logic [MODE_W-1:0]  f_mode;
  logic [DW-1:0]      f_vec;
  logic [DW-1:0]      f_sr;
  logic [DW-1:0]      f_link;
  logic               f_saves;

  exc_req_gate #(.DW(DW)) u_gate (
    .req_reset (req_reset),
    .req_dabt  (req_dabt),
    .req_fiq   (req_fiq),
    .req_irq   (req_irq),
    .req_pabt  (req_pabt),
    .req_undef (req_undef),
    .req_swi   (req_swi),
    .sr_in     (sr_in),
    .ranked    (ranked_req)
  );

  exc_prio_pick #(.N(NUM_EXC), .IW(KIND_W)) u_pick (
    .req   (ranked_req),
    .grant (grant_vec),
    .idx   (win_idx),
    .any   (win_any)
  );

  assign win_kind = exc_kind_e'(win_idx);
  assign take     = entry_en & win_any;

  exc_frame_build #(.DW(DW), .VEC_BASE(VEC_BASE)) u_frame (
    .kind    (win_kind),
    .pc_in   (pc_in),
    .sr_in   (sr_in),
    .mode    (f_mode),
    .vec     (f_vec),
    .sr_next (f_sr),
    .link    (f_link),
    .saves   (f_saves)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      vector_addr <= '0;
      mode_out    <= '0;
      sr_we       <= 1'b0;
      sr_new      <= '0;
      spsr_we     <= 1'b0;
      spsr_data   <= '0;
      lr_we       <= 1'b0;
      lr_data     <= '0;
    end else if (take) begin
      redirect    <= 1'b1;
      vector_addr <= f_vec;
      mode_out    <= f_mode;
      sr_we       <= 1'b1;
      sr_new      <= f_sr;
      spsr_we     <= f_saves;
      spsr_data   <= f_saves ? sr_in : '0;
      lr_we       <= f_saves;
      lr_data     <= f_saves ? f_link : '0;
    end else begin
      redirect    <= 1'b0;
      vector_addr <= '0;
      mode_out    <= '0;
      sr_we       <= 1'b0;
      sr_new      <= '0;
      spsr_we     <= 1'b0;
      spsr_data   <= '0;
      lr_we       <= 1'b0;
      lr_data     <= '0;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_entry_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               entry_en,
  input logic               req_irq,
  input logic               req_reset,
  input logic               req_dabt,
  input logic               req_fiq,
  input logic               req_pabt,
  input logic               req_undef,
  input logic               req_swi,
  input logic [DW-1:0]      pc_in,
  input logic [DW-1:0]      sr_in,
  input logic [NUM_EXC-1:0] grant_vec,
  input logic               redirect,
  input logic [DW-1:0]      vector_addr,
  input logic [MODE_W-1:0]  mode_out,
  input logic               sr_we,
  input logic [DW-1:0]      sr_new,
  input logic               spsr_we,
  input logic [DW-1:0]      spsr_data,
  input logic               lr_we,
  input logic [DW-1:0]      lr_data
);

  logic others_idle;
  assign others_idle = ~(req_reset | req_dabt | req_fiq | req_pabt | req_undef | req_swi);

  p_quiet_without_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_en |=> (!redirect && !sr_we && !spsr_we && !lr_we));

  p_strobe_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we == redirect);

  p_single_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_link_plus4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (lr_data == $past(pc_in) + DW'(4)));

  p_saved_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (spsr_data == $past(sr_in)));

  p_reset_no_bank_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && vector_addr == VEC_BASE) |-> (!spsr_we && !lr_we));

  p_imask_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> sr_new[I_POS]);

  p_fast_sets_f_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mode_out == MODE_FIQ) |-> sr_new[F_POS]);

  p_masked_irq_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_en && req_irq && sr_in[I_POS] && others_idle) |=> !redirect);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DW(DW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .entry_en    (entry_en),
  .req_irq     (req_irq),
  .req_reset   (req_reset),
  .req_dabt    (req_dabt),
  .req_fiq     (req_fiq),
  .req_pabt    (req_pabt),
  .req_undef   (req_undef),
  .req_swi     (req_swi),
  .pc_in       (pc_in),
  .sr_in       (sr_in),
  .grant_vec   (grant_vec),
  .redirect    (redirect),
  .vector_addr (vector_addr),
  .mode_out    (mode_out),
  .sr_we       (sr_we),
  .sr_new      (sr_new),
  .spsr_we     (spsr_we),
  .spsr_data   (spsr_data),
  .lr_we       (lr_we),
  .lr_data     (lr_data)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

  localparam int          DW   = 32;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_en = 1'b0;
  logic req_reset = 1'b0, req_dabt = 1'b0, req_fiq = 1'b0, req_irq = 1'b0;
  logic req_pabt = 1'b0, req_undef = 1'b0, req_swi = 1'b0;
  logic [31:0] pc_in = '0, sr_in = '0;
  logic        redirect, sr_we, spsr_we, lr_we;
  logic [31:0] vector_addr, sr_new, spsr_data, lr_data;
  logic [4:0]  mode_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.DW(DW), .VEC_BASE(BASE)) u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .entry_en(entry_en),
    .req_reset(req_reset), .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_undef(req_undef), .req_swi(req_swi),
    .pc_in(pc_in), .sr_in(sr_in),
    .redirect(redirect), .vector_addr(vector_addr), .mode_out(mode_out),
    .sr_we(sr_we), .sr_new(sr_new), .spsr_we(spsr_we), .spsr_data(spsr_data),
    .lr_we(lr_we), .lr_data(lr_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Bench order of request bits: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  // Returns selected bit index, or -1 when nothing can be taken
  function automatic int pick(input logic [6:0] r, input bit imask, input bit fmask);
    logic [6:0] live;
    live = r;
    if (imask) live[5] = 1'b0;
    if (fmask) live[6] = 1'b0;
    if (live[0]) return 0;
    if (live[4]) return 4;
    if (live[6]) return 6;
    if (live[5]) return 5;
    if (live[3]) return 3;
    if (live[1]) return 1;
    if (live[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] mode_of(input int b);
    logic [4:0] m;
    m = 5'h13;
    if (b == 6) m = 5'h11;
    if (b == 5) m = 5'h12;
    if (b == 3 || b == 4) m = 5'h17;
    if (b == 1) m = 5'h1B;
    return m;
  endfunction

  function automatic logic [31:0] ofs_of(input int b);
    if (b == 5) return 32'h18;
    if (b == 6) return 32'h1C;
    return 32'(b) * 4;
  endfunction

  task automatic drive(input bit en, input logic [6:0] r, input logic [31:0] pc, input logic [31:0] sr);
    entry_en  = en;
    req_reset = r[0]; req_undef = r[1]; req_swi = r[2]; req_pabt = r[3];
    req_dabt  = r[4]; req_irq = r[5]; req_fiq = r[6];
    pc_in = pc; sr_in = sr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 strobes", {28'b0, sr_we, spsr_we, lr_we, 1'b0}, 32'h0);
    chk("R1 data", vector_addr | sr_new | spsr_data | lr_data | {27'b0, mode_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        bit          im, fm;
        int          w, cnt;
        logic [31:0] sr, pc, exp_sr;
        im = m[1]; fm = m[0];
        sr = (32'h3C00_5A00 ^ (32'(r) << 16) ^ (32'(m) << 12)) & ~32'hFF;
        sr = sr | 32'h10 | (im ? 32'h80 : 32'h0) | (fm ? 32'h40 : 32'h0);
        pc = 32'h0000_8000 + 32'(r) * 32'h44 + 32'(m) * 32'h1000;
        drive(1'b1, 7'(r), pc, sr);
        w = pick(7'(r), im, fm);
        cnt = 0;
        for (int b = 0; b < 7; b++)
          if (r[b] && !(b == 5 && im) && !(b == 6 && fm)) cnt++;
        @(negedge clk);
        if (w < 0) begin
          chk("R5 no entry when nothing unmasked", {31'b0, redirect}, 32'h0);
          chk("R5 no writes", {29'b0, sr_we, spsr_we, lr_we}, 32'h0);
        end else begin
          chk("R9 redirect and sr_we", {30'b0, redirect, sr_we}, 32'h3);
          if (cnt > 1) chk("R2 priority winner vector", vector_addr, BASE + ofs_of(w));
          else         chk("R4 vector", vector_addr, BASE + ofs_of(w));
          chk("R3 mode", {27'b0, mode_out}, {27'b0, mode_of(w)});
          exp_sr = (sr & ~32'h1F) | {27'b0, mode_of(w)} | 32'h80;
          if (w == 0 || w == 6) exp_sr = exp_sr | 32'h40;
          chk("R6 new status", sr_new, exp_sr);
          if (w == 0) begin
            chk("R7 reset skips saved status", {31'b0, spsr_we}, 32'h0);
            chk("R8 reset skips link", {31'b0, lr_we}, 32'h0);
          end else begin
            chk("R7 saved status write", {31'b0, spsr_we}, 32'h1);
            chk("R7 saved status value", spsr_data, sr);
            chk("R8 link write", {31'b0, lr_we}, 32'h1);
            chk("R8 link value", lr_data, pc + 32'd4);
          end
        end
      end
    end

    // R10: requests present but strobe low
    drive(1'b0, 7'h7F, 32'h1234, 32'h10);
    @(negedge clk);
    chk("R10 strobes idle", {28'b0, redirect, sr_we, spsr_we, lr_we}, 32'h0);
    @(negedge clk);
    chk("R10 strobes idle second cycle", {28'b0, redirect, sr_we, spsr_we, lr_we}, 32'h0);

    // R8: return address wraps at the top of the range (software interrupt)
    drive(1'b1, 7'b000_0100, 32'hFFFF_FFFC, 32'h10);
    @(negedge clk);
    chk("R8 link wraps", lr_data, 32'h0);
    chk("R4 software interrupt vector", vector_addr, BASE + 32'h8);

    // R9: a single entry is one cycle wide
    drive(1'b0, 7'b000_0100, 32'h0, 32'h10);
    @(negedge clk);
    chk("R9 strobe drops after one cycle", {31'b0, redirect}, 32'h0);

    // R5: masked fast interrupt with a normal interrupt below it
    drive(1'b1, 7'b110_0000, 32'h400, 32'h50);
    @(negedge clk);
    chk("R5 masked fast interrupt passes to normal", vector_addr, BASE + 32'h18);
    chk("R6 bit 6 kept on normal entry", {31'b0, sr_new[6]}, 32'h1);

    // R1: reset in the middle clears outputs
    drive(1'b1, 7'b000_0001, 32'h0, 32'h10);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears redirect", {31'b0, redirect}, 32'h0);
    chk("R1 async reset clears vector", vector_addr, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule